// File: doc/BRIEF.md
# Coprocessor Instruction Cancel Queue

This block is a short token queue between a processor core and a loosely coupled coprocessor pipeline. For every instruction the core has already sent to the coprocessor, the core later pushes one token. A token holds a cancel bit and a flush tag. A core can drop an instruction that fails its condition codes after the instruction has been issued, and the token lets both pipelines drop it in step.

The coprocessor's first execute stage reads the tokens in arrival order. A token is popped whenever that stage holds a valid instruction and the queue has an entry. If the token's cancel bit is set, the block raises a kill pulse and the instruction is removed. If the bit is clear, the block raises an advance pulse and the instruction moves on to the second execute stage. When the queue is empty, the first execute stage stalls and neither pulse is raised.

The core gets no back-pressure. A push that arrives while the queue is full and no pop frees a slot is dropped without trace.

Top module: `cancel_token_queue`

## Requirements
- R1: When `pushValid` is high and a slot is free, the token (`pushCancel`, `pushTag`) is stored at the rising edge. When the queue was empty, the token appears on `headCancel` and `headTag` in the next cycle and `empty` goes low. `full` is high exactly when DEPTH (default 3) tokens are held.
- R2: When `full` is high and no pop happens in that cycle, a high `pushValid` is ignored. No token is stored and the queue contents are unchanged.
- R3: Tokens leave the queue in the order in which they were accepted.
- R4: A pop happens in a cycle only when `ex1Valid` is high and `empty` is low. While `empty` is high, `kill` and `advance` both stay low, which stalls the first execute stage.
- R5: In a pop cycle, `kill` is high if the head cancel bit is 1 and `advance` is high if it is 0. Both pulses are combinational in that same cycle, and the head token is removed at the next rising edge.
- R6: A synchronous active-high `rst` empties the queue. After a reset edge, `empty` is high, `full` is low, and `kill` and `advance` are low.
- R7: When the queue is full and a push and a pop happen in the same cycle, both take effect. The head token leaves, the new token takes the freed slot at the tail, and the queue stays full.
- R8: When the queue is neither full nor empty and a push and a pop happen in the same cycle, both take effect and the number of held tokens is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pushValid | input | 1 | Core offers a token this cycle |
| pushCancel | input | 1 | Cancel bit of the offered token (1 = drop the instruction) |
| pushTag | input | TAG_W (4) | Flush tag of the offered token |
| ex1Valid | input | 1 | First execute stage holds a valid instruction |
| full | output | 1 | All DEPTH slots hold tokens |
| empty | output | 1 | No token is held |
| headCancel | output | 1 | Cancel bit of the oldest token |
| headTag | output | TAG_W (4) | Flush tag of the oldest token |
| kill | output | 1 | Pop cycle with cancel set: remove the execute-stage instruction |
| advance | output | 1 | Pop cycle with cancel clear: forward the instruction to the second execute stage |

## Verification
The assertions check the following on every cycle:
- `full` and `empty` are never high together.
- While the queue is empty, no pulse is raised.
- In every pop cycle, exactly one of `kill` and `advance` is raised, and it matches `headCancel`.
- A token pushed into an empty queue appears at the head in the next cycle.
- With the queue full and no pop, the queue stays full and its head does not move.
- Simultaneous push and pop keep the occupancy.

Some behaviour only the directed scenarios can show. These are the full first-in-first-out order across several tokens, and the fact that a push dropped while full never appears at a later pop. They also include the tail placement of a token accepted in a full push-and-pop cycle, and the clearing of a partly filled queue by reset.

// File: rtl/ctq_pkg.sv
package ctq_pkg;
  // Width of the slot index carried in the strobe struct (supports up to 16 slots)
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             shift;    // move every slot one step toward the head
    logic             load;     // write the incoming token
    logic [IDX_W-1:0] loadIdx;  // slot that receives the incoming token
  } ctq_strobe_t;
endpackage

// File: rtl/ctq_ctrl.sv
module ctq_ctrl
  import ctq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic [DEPTH-1:0] validVec,
  input  logic             pushValid,
  input  logic             ex1Valid,
  input  logic             headCancel,
  output logic             full,
  output logic             empty,
  output logic             kill,
  output logic             advance,
  output ctq_strobe_t      strobe
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          pop;
  logic          accept;

  // Slots are packed toward the head, so the number held is the popcount
  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++) begin
      count = count + CW'(validVec[i]);
    end
  end

  assign empty   = ~validVec[0];
  assign full    = &validVec;
  assign pop     = ex1Valid & ~empty;
  assign kill    = pop & headCancel;
  assign advance = pop & ~headCancel;
  // A full queue still accepts when the head leaves in the same cycle
  assign accept  = pushValid & (~full | pop);

  always_comb begin
    strobe.shift = pop;
    strobe.load  = accept;
    if (pop) begin
      strobe.loadIdx = IDX_W'(count - CW'(1));
    end else begin
      strobe.loadIdx = IDX_W'(count);
    end
  end
endmodule

// File: rtl/ctq_datapath.sv
module ctq_datapath
  import ctq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctq_strobe_t      strobe,
  input  logic             inCancel,
  input  logic [TAG_W-1:0] inTag,
  output logic [DEPTH-1:0] validVec,
  output logic             headCancel,
  output logic [TAG_W-1:0] headTag
);
  logic             slotValid  [DEPTH];
  logic             slotCancel [DEPTH];
  logic [TAG_W-1:0] slotTag    [DEPTH];

  logic             upValid  [DEPTH];
  logic             upCancel [DEPTH];
  logic [TAG_W-1:0] upTag    [DEPTH];

  // Value each slot takes on a shift: its neighbour nearer the tail
  for (genvar i = 0; i < DEPTH; i++) begin : g_up
    if (i < DEPTH - 1) begin : g_mid
      assign upValid[i]  = slotValid[i+1];
      assign upCancel[i] = slotCancel[i+1];
      assign upTag[i]    = slotTag[i+1];
    end else begin : g_tail
      assign upValid[i]  = 1'b0;
      assign upCancel[i] = 1'b0;
      assign upTag[i]    = '0;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) begin
        slotValid[i] <= 1'b0;
      end else if (strobe.load && strobe.loadIdx == IDX_W'(i)) begin
        slotValid[i]  <= 1'b1;
        slotCancel[i] <= inCancel;
        slotTag[i]    <= inTag;
      end else if (strobe.shift) begin
        slotValid[i]  <= upValid[i];
        slotCancel[i] <= upCancel[i];
        slotTag[i]    <= upTag[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      validVec[i] = slotValid[i];
    end
  end

  assign headCancel = slotCancel[0];
  assign headTag    = slotTag[0];
endmodule

// File: rtl/cancel_token_queue.sv
module cancel_token_queue
  import ctq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushValid,
  input  logic             pushCancel,
  input  logic [TAG_W-1:0] pushTag,
  input  logic             ex1Valid,
  output logic             full,
  output logic             empty,
  output logic             headCancel,
  output logic [TAG_W-1:0] headTag,
  output logic             kill,
  output logic             advance
);
  ctq_strobe_t      strobe;
  logic [DEPTH-1:0] validVec;

  ctq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .validVec  (validVec),
    .pushValid (pushValid),
    .ex1Valid  (ex1Valid),
    .headCancel(headCancel),
    .full      (full),
    .empty     (empty),
    .kill      (kill),
    .advance   (advance),
    .strobe    (strobe)
  );

  ctq_datapath #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .inCancel  (pushCancel),
    .inTag     (pushTag),
    .validVec  (validVec),
    .headCancel(headCancel),
    .headTag   (headTag)
  );
endmodule

// File: rtl/ctq_checker.sv
module ctq_checker #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pushValid,
  input logic             pushCancel,
  input logic [TAG_W-1:0] pushTag,
  input logic             ex1Valid,
  input logic             full,
  input logic             empty,
  input logic             headCancel,
  input logic [TAG_W-1:0] headTag,
  input logic             kill,
  input logic             advance
);
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  a_r1_push_into_empty: assert property (@(posedge clk) disable iff (rst)
    (empty && pushValid) |=>
      (!empty && headTag == $past(pushTag) && headCancel == $past(pushCancel)));

  a_r2_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && !ex1Valid) |=>
      (full && $stable(headTag) && $stable(headCancel)));

  a_r4_empty_stall: assert property (@(posedge clk) disable iff (rst)
    empty |-> (!kill && !advance));

  a_r5_decision: assert property (@(posedge clk) disable iff (rst)
    (ex1Valid && !empty) |-> ((kill == headCancel) && (advance == !headCancel)));

  a_r6_reset_empties: assert property (@(posedge clk)
    rst |=> (empty && !full));

  a_r7_full_push_pop: assert property (@(posedge clk) disable iff (rst)
    (full && pushValid && ex1Valid) |=> full);

  a_r8_mid_push_pop: assert property (@(posedge clk) disable iff (rst)
    (!full && !empty && pushValid && ex1Valid) |=> (!empty && !full));
endmodule

bind cancel_token_queue ctq_checker #(.TAG_W(TAG_W)) u_ctq_checker (
  .clk       (clk),
  .rst       (rst),
  .pushValid (pushValid),
  .pushCancel(pushCancel),
  .pushTag   (pushTag),
  .ex1Valid  (ex1Valid),
  .full      (full),
  .empty     (empty),
  .headCancel(headCancel),
  .headTag   (headTag),
  .kill      (kill),
  .advance   (advance)
);

// File: tb/cancel_token_queue_bench.sv
`timescale 1ns/1ps
module cancel_token_queue_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       pushValid, pushCancel, ex1Valid;
  logic [3:0] pushTag;
  logic       full, empty, headCancel, kill, advance;
  logic [3:0] headTag;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cancel_token_queue u_cancel_token_queue (
    .clk(clk), .rst(rst), .pushValid(pushValid), .pushCancel(pushCancel),
    .pushTag(pushTag), .ex1Valid(ex1Valid), .full(full), .empty(empty),
    .headCancel(headCancel), .headTag(headTag), .kill(kill), .advance(advance)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive inputs after a falling edge; outputs are then settled for this cycle
  task automatic drive(input bit pv, input bit pc, input int pt, input bit ev);
    @(negedge clk);
    pushValid  = pv;
    pushCancel = pc;
    pushTag    = 4'(pt);
    ex1Valid   = ev;
    #2;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    pushValid = 0; pushCancel = 0; pushTag = 0; ex1Valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Pop the head and check its tag and decision
  task automatic popExpect(input string req, input int tag, input bit cancel);
    drive(0, 0, 0, 1);
    chk(req, "head tag", int'(headTag), tag);
    chk(req, "kill", int'(kill), int'(cancel));
    chk(req, "advance", int'(advance), int'(!cancel));
  endtask

  task automatic testReset();
    idle();
    chk("R6", "empty after reset", int'(empty), 1);
    chk("R6", "full after reset", int'(full), 0);
    chk("R6", "kill after reset", int'(kill), 0);
    chk("R6", "advance after reset", int'(advance), 0);
  endtask

  task automatic testStall();
    drive(0, 0, 0, 1);
    chk("R4", "kill while empty", int'(kill), 0);
    chk("R4", "advance while empty", int'(advance), 0);
    idle();
    chk("R4", "still empty", int'(empty), 1);
  endtask

  task automatic testSingle();
    drive(1, 1, 5, 0);
    idle();
    chk("R1", "empty after push", int'(empty), 0);
    chk("R1", "head tag", int'(headTag), 5);
    chk("R1", "head cancel", int'(headCancel), 1);
    popExpect("R5", 5, 1'b1);
    idle();
    chk("R5", "empty after pop", int'(empty), 1);
  endtask

  task automatic testOrder();
    drive(1, 0, 1, 0);
    drive(1, 1, 2, 0);
    drive(1, 0, 3, 0);
    idle();
    chk("R1", "full with three", int'(full), 1);
    popExpect("R3", 1, 1'b0);
    popExpect("R3", 2, 1'b1);
    popExpect("R3", 3, 1'b0);
    idle();
    chk("R3", "empty after drain", int'(empty), 1);
  endtask

  task automatic testOverflow();
    drive(1, 0, 4, 0);
    drive(1, 0, 5, 0);
    drive(1, 0, 6, 0);
    drive(1, 1, 9, 0);
    chk("R2", "full when dropped push offered", int'(full), 1);
    idle();
    chk("R2", "head unchanged", int'(headTag), 4);
    popExpect("R2", 4, 1'b0);
    popExpect("R2", 5, 1'b0);
    popExpect("R2", 6, 1'b0);
    idle();
    chk("R2", "dropped token absent", int'(empty), 1);
  endtask

  task automatic testFullPushPop();
    drive(1, 0, 7, 0);
    drive(1, 1, 8, 0);
    drive(1, 0, 9, 0);
    drive(1, 1, 10, 1);
    chk("R7", "advance on full pop", int'(advance), 1);
    idle();
    chk("R7", "still full", int'(full), 1);
    popExpect("R7", 8, 1'b1);
    popExpect("R7", 9, 1'b0);
    popExpect("R7", 10, 1'b1);
    idle();
    chk("R7", "empty after drain", int'(empty), 1);
  endtask

  task automatic testMidPushPop();
    drive(1, 1, 11, 0);
    drive(1, 0, 12, 1);
    chk("R8", "kill on head", int'(kill), 1);
    idle();
    chk("R8", "not empty", int'(empty), 0);
    chk("R8", "not full", int'(full), 0);
    popExpect("R8", 12, 1'b0);
    idle();
    chk("R8", "empty after drain", int'(empty), 1);
  endtask

  task automatic testMidReset();
    drive(1, 0, 13, 0);
    drive(1, 0, 14, 0);
    idle();
    chk("R6", "holding before reset", int'(empty), 0);
    doReset();
    drive(0, 0, 0, 1);
    chk("R6", "empty after mid reset", int'(empty), 1);
    chk("R6", "no advance after mid reset", int'(advance), 0);
  endtask

  initial begin
    doReset();
    testReset();
    testStall();
    testSingle();
    testOrder();
    testOverflow();
    testFullPushPop();
    testMidPushPop();
    testMidReset();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end
endmodule